// File: doc/BRIEF.md
# Power-Up Multi-Sample Data Capture

This block records the values of a data bus during the first few clock cycles after initialization. It is meant for bring-up. The word present at each of the first `SAMPLES` rising clock edges after reset is released is stored in its own register, one word per cycle, at the full clock rate. After those cycles the capture window closes for good. The stored words stay unchanged until the next reset, which opens a new window.

A sample-select input chooses which stored word is shown on the display output. Select values wrap modulo `SAMPLES`. For words wider than 8 bits, the display is 8 bits wide and a byte-select input picks which byte of the chosen word appears. Byte 0 is the least significant byte. A separate indicator is 1 whenever sample 0 is the one on display. The inputs and outputs are plain level signals with no handshake, because capture is tied to fixed cycles and not to data availability.

`SAMPLES` may be 2, 4 or 8, and `WIDTH` may be 2, 4, 8, 16 or 32.

Top module: `pwrup_capture`

## Requirements
- R1: While `rst_n` is low, every stored sample reads as zero on `disp`. With `samp_sel` = 0, `sel0_shown` is 1.
- R2: The first rising edge of `clk` with `rst_n` high is cycle 0. Sample k (0 ≤ k < SAMPLES) holds the value of `din` at rising edge k.
- R3: After edge SAMPLES-1, no later value of `din` changes any stored sample, until reset.
- R4: A new reset opens a new window, and the samples are then taken again from the new cycle 0.
- R5: `disp` shows the sample whose index is `samp_sel`.
- R6: A `samp_sel` value of SAMPLES or more selects sample `samp_sel` mod SAMPLES.
- R7: When WIDTH > 8, `disp` carries bits [8b+7:8b] of the selected sample, where b is `byte_sel`, so byte 0 is the least significant byte. When WIDTH ≤ 8, `disp` is the whole sample and `byte_sel` has no effect.
- R8: `sel0_shown` is 1 exactly when `samp_sel` mod SAMPLES equals 0.
- R9: The internal cycle index stops advancing once the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low initialization. Clears the samples and opens the capture window |
| din | input | WIDTH | Data bus being captured |
| samp_sel | input | SEL_W | Which sample to display (taken modulo SAMPLES) |
| byte_sel | input | BSEL_W | Byte of the selected sample to display (used when WIDTH > 8) |
| disp | output | DISP_W | Displayed sample or byte (8 bits when WIDTH > 8, otherwise WIDTH bits) |
| sel0_shown | output | 1 | 1 when sample 0 is displayed |

## Verification
The embedded properties check on every cycle the following:
- The window closes right after the last capture cycle and never reopens without reset.
- The cycle index freezes once the window has closed.
- Each sample register loads the bus only in its own cycle, and holds its value once closed.
- When the indicator is high, the display shows the matching part of sample 0.

Whether the stored words match what was driven on the bus at cycles 0 to SAMPLES-1 is shown only by the bench scenarios. The same is true for the select wrap-around, the byte ordering and the re-arming on a second reset. The bench sweeps every select and byte-select value over several data patterns and resets.

// File: rtl/pwrup_cap_pkg.sv
package pwrup_cap_pkg;
  localparam int BYTE_W = 8;

  function automatic int disp_width(input int w);
    return (w > BYTE_W) ? BYTE_W : w;
  endfunction

  function automatic int byte_count(input int w);
    return (w > BYTE_W) ? (w / BYTE_W) : 1;
  endfunction
endpackage

// File: rtl/cap_window.sv
module cap_window #(
  parameter int SAMPLES = 4,
  localparam int IDXW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            cap_en,
  output logic [IDXW-1:0] idx
);
  localparam logic [IDXW-1:0] LAST = IDXW'(SAMPLES - 1);

  logic [IDXW-1:0] idx_nxt;

  generate
    if (SAMPLES == 2) begin : g_toggle
      assign idx_nxt = ~idx;
    end else begin : g_count
      assign idx_nxt = idx + IDXW'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en <= 1'b1;
      idx    <= '0;
    end else if (cap_en) begin
      idx <= idx_nxt;
      if (idx == LAST) cap_en <= 1'b0;
    end
  end

  // R3: the window shuts right after the last capture cycle
  assert_window_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && idx == LAST) |=> !cap_en);
  // R4: only a reset reopens the window
  assert_no_reopen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> !cap_en);
  // R9: index frozen while closed
  assert_idx_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(idx));
endmodule

// File: rtl/sample_bank.sv
module sample_bank #(
  parameter int SAMPLES = 4,
  parameter int WIDTH   = 16,
  localparam int IDXW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap_en,
  input  logic [IDXW-1:0]               idx,
  input  logic [WIDTH-1:0]              din,
  output logic [SAMPLES-1:0][WIDTH-1:0] bank
);
  generate
    for (genvar i = 0; i < SAMPLES; i++) begin : g_slot
      logic load;
      assign load = cap_en && (idx == IDXW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bank[i] <= '0;
        else if (load) bank[i] <= din;
      end

      // R2: slot i takes the bus in its own cycle
      assert_slot_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && idx == IDXW'(i)) |=> bank[i] == $past(din));
      // R3: contents kept after window closes
      assert_slot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(bank[i]));
    end
  endgenerate
endmodule

// File: rtl/view_mux.sv
module view_mux
  import pwrup_cap_pkg::*;
#(
  parameter int SAMPLES = 4,
  parameter int WIDTH   = 16,
  parameter int SEL_W   = 3,
  parameter int BSEL_W  = 1,
  localparam int IDXW   = (SAMPLES > 1) ? $clog2(SAMPLES) : 1,
  localparam int DISP_W = disp_width(WIDTH)
) (
  input  logic [SAMPLES-1:0][WIDTH-1:0] bank,
  input  logic [SEL_W-1:0]              samp_sel,
  input  logic [BSEL_W-1:0]             byte_sel,
  output logic [DISP_W-1:0]             disp,
  output logic                          sel0_shown
);
  logic [IDXW-1:0]  pick;
  logic [WIDTH-1:0] word;

  assign pick       = samp_sel[IDXW-1:0];
  assign word       = bank[pick];
  assign sel0_shown = (pick == '0);

  generate
    if (SEL_W > IDXW) begin : g_sel_hi
      logic unused_sel_hi;
      assign unused_sel_hi = ^samp_sel[SEL_W-1:IDXW];
    end
    if (WIDTH > BYTE_W) begin : g_bytes
      assign disp = word[byte_sel*BYTE_W +: BYTE_W];
    end else begin : g_whole
      logic unused_bsel;
      assign unused_bsel = ^byte_sel;
      assign disp        = word;
    end
  endgenerate
endmodule

// File: rtl/pwrup_capture.sv
module pwrup_capture
  import pwrup_cap_pkg::*;
#(
  parameter int SAMPLES = 4,
  parameter int WIDTH   = 16,
  parameter int SEL_W   = 3,
  localparam int BYTES  = byte_count(WIDTH),
  localparam int BSEL_W = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int DISP_W = disp_width(WIDTH),
  localparam int IDXW   = (SAMPLES > 1) ? $clog2(SAMPLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  din,
  input  logic [SEL_W-1:0]  samp_sel,
  input  logic [BSEL_W-1:0] byte_sel,
  output logic [DISP_W-1:0] disp,
  output logic              sel0_shown
);
  logic                          cap_en;
  logic [IDXW-1:0]               idx;
  logic [SAMPLES-1:0][WIDTH-1:0] bank;

  cap_window #(.SAMPLES(SAMPLES)) u_win (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .idx(idx)
  );

  sample_bank #(.SAMPLES(SAMPLES), .WIDTH(WIDTH)) u_bank (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .idx(idx), .din(din), .bank(bank)
  );

  view_mux #(.SAMPLES(SAMPLES), .WIDTH(WIDTH), .SEL_W(SEL_W), .BSEL_W(BSEL_W)) u_view (
    .bank(bank), .samp_sel(samp_sel), .byte_sel(byte_sel),
    .disp(disp), .sel0_shown(sel0_shown)
  );

  generate
    if (WIDTH > BYTE_W) begin : g_chk_b
      // R8 / R7: indicator high means byte of sample 0 is on display
      assert_sel0_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel0_shown |-> disp == bank[0][byte_sel*BYTE_W +: BYTE_W]);
    end else begin : g_chk_w
      assert_sel0_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel0_shown |-> disp == bank[0]);
    end
  endgenerate
endmodule

// File: tb/sim_pwrup_capture.sv
`timescale 1ns/1ps
module sim_pwrup_capture;
  localparam int S = 4;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] din = '0;
  logic [2:0]   samp_sel = '0;
  logic [0:0]   byte_sel = '0;
  logic [7:0]   disp;
  logic         sel0_shown;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pwrup_capture #(.SAMPLES(S), .WIDTH(W), .SEL_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .samp_sel(samp_sel),
    .byte_sel(byte_sel), .disp(disp), .sel0_shown(sel0_shown)
  );

  function automatic logic [W-1:0] pat(input int run, input int k);
    return W'(16'hA5C3 ^ (run * 16'h1357) ^ (k * 16'h0F11) ^ (k << 12));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sweep(input int run, input string req);
    for (int s = 0; s < 8; s++) begin
      for (int b = 0; b < 2; b++) begin
        @(negedge clk);
        samp_sel = 3'(s);
        byte_sel = 1'(b);
        #1;
        check(req, {24'd0, disp}, {24'd0, 8'(pat(run, s % S) >> (8 * b))});
        check("R8", {31'd0, sel0_shown}, {31'd0, (s % S) == 0});
      end
    end
  endtask

  task automatic one_run(input int run);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    samp_sel = 3'd0;
    byte_sel = 1'b0;
    #1;
    check("R1", {24'd0, disp}, 32'd0);
    check("R1", {31'd0, sel0_shown}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    din = pat(run, 0);
    for (int k = 1; k < S; k++) begin
      @(negedge clk);
      din = pat(run, k);
    end
    // R3: disturb the bus after the window
    for (int g = 0; g < 6; g++) begin
      @(negedge clk);
      din = ~pat(run + 7, g);
    end
    sweep(run, run == 0 ? "R2/R5/R6/R7" : "R4/R3");
  endtask

  initial begin
    for (int r = 0; r < 3; r++) one_run(r);
    // R7 byte order: sample 1 low byte vs high byte
    @(negedge clk);
    samp_sel = 3'd1; byte_sel = 1'b1; #1;
    check("R7", {24'd0, disp}, {24'd0, pat(2, 1)[15:8]});
    // R6: select 6 wraps to sample 2
    samp_sel = 3'd6; byte_sel = 1'b0; #1;
    check("R6", {24'd0, disp}, {24'd0, pat(2, 2)[7:0]});
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule